// File: doc/BRIEF.md
# Per-Interrupt State Tracker for a Multi-CPU Distributor

This block holds the live state of every interrupt in a small interrupt distributor shared by several CPUs. For each interrupt it keeps enable, stored-pending, active, group and sampled-line bits, each as a bitmask with one bit per CPU. It also keeps one trigger-type flag (edge or level) and one handling-model flag (one-CPU or all-CPU acknowledge). An 8-bit priority is held per interrupt. The lowest-numbered interrupts are private: each CPU has its own priority copy for them. The rest share one priority value across all CPUs.

A single command port takes a one-cycle valid pulse with an opcode, an interrupt number, a requesting CPU index and a data byte. Commands take effect at the next clock edge. A query port selects one interrupt and one CPU and returns, combinationally from the registered state, whether that interrupt is enabled, pending, active or in group 1, and what its priority is. Pending is derived rather than simply stored. A level-triggered interrupt whose sampled line is high reads as pending even when its stored bit is clear. The parameter `LEGACY` selects an older rule in which only the stored bit counts.

Top module: `irq_state_tracker`

## Requirements
- R1: After reset every bit of state and every priority is zero and every interrupt is level-triggered with the one-CPU model, so any query returns zero on all outputs.
- R2: With `LEGACY`=0, a query reads pending when the stored pending bit for that CPU is set, or when the interrupt is level-triggered and that CPU's line, sampled one clock earlier, is high; when the line drops, pending falls unless the bit is stored.
- R3: With `LEGACY`=1, pending equals the stored bit only, and line levels never make an interrupt read as pending.
- R4: For an edge-triggered interrupt, a rising line for one CPU sets only that CPU's stored pending bit, and the bit stays set after the line falls.
- R5: Opcodes on `cmd_op_i` are 1 enable-set, 2 enable-clear, 3 pending-set, 4 pending-clear, 5 active-set, 6 active-clear, 7 group-set, 8 group-clear, 9 make edge-triggered, 10 make level-triggered, 11 all-CPU model, 12 one-CPU model, 13 write priority from `cmd_data_i`. Enable-set/clear, group-set/clear, pending-set and active-set change only the requesting CPU's bit.
- R6: Pending-clear clears all CPUs' stored bits when the interrupt uses the all-CPU model, and only the requester's bit otherwise; a level-triggered interrupt with its line high still reads pending after the clear.
- R7: Active-clear clears only the requester's bit for private interrupts (number below 32) and clears every CPU's bit for shared ones.
- R8: A priority write to a private interrupt lands only in the requester's copy; a write to a shared interrupt is seen by every CPU.
- R9: When an edge-triggered rising line and a pending-clear for the same CPU and interrupt meet in one cycle, the bit ends set.
- R10: Commands naming an interrupt number of 96 or above change no state, and queries of such numbers return zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| cmd_valid_i | input | 1 | Command strobe, one cycle |
| cmd_op_i | input | 4 | Command opcode (see R5) |
| cmd_irq_i | input | 7 | Interrupt number of the command |
| cmd_cpu_i | input | 2 | Requesting CPU |
| cmd_data_i | input | 8 | Priority value for opcode 13 |
| line_i | input | 384 | Interrupt lines, bit irq*4+cpu |
| q_irq_i | input | 7 | Interrupt number queried |
| q_cpu_i | input | 2 | CPU queried |
| q_enabled_o | output | 1 | Enable bit of the queried pair |
| q_pending_o | output | 1 | Derived pending of the queried pair |
| q_active_o | output | 1 | Active bit of the queried pair |
| q_group_o | output | 1 | Group bit of the queried pair |
| q_prio_o | output | 8 | Priority seen by the queried CPU |

## Verification
A wrong CPU mask on a clear shows up as soon as a second CPU that still held the bit is queried, in the cycle right after the command. A stale or wrongly chosen trigger flag shows up as pending that does not follow the line one clock after it moves, or that is lost when the line falls. A misplaced priority index shows up as a value leaking into another CPU's bank copy or into an aliased interrupt number on the next query.

// File: rtl/irqst_pkg.sv
package irqst_pkg;
  typedef enum logic [3:0] {
    OP_NOP        = 4'd0,
    OP_EN_SET     = 4'd1,
    OP_EN_CLR     = 4'd2,
    OP_PEND_SET   = 4'd3,
    OP_PEND_CLR   = 4'd4,
    OP_ACT_SET    = 4'd5,
    OP_ACT_CLR    = 4'd6,
    OP_GRP_SET    = 4'd7,
    OP_GRP_CLR    = 4'd8,
    OP_TRIG_EDGE  = 4'd9,
    OP_TRIG_LEVEL = 4'd10,
    OP_MODEL_ALL  = 4'd11,
    OP_MODEL_ONE  = 4'd12,
    OP_PRIO_WR    = 4'd13
  } op_e;
endpackage

// File: rtl/irqst_cmd_decode.sv
module irqst_cmd_decode
  import irqst_pkg::*;
#(
  parameter int NCPU  = 4,
  parameter int NIRQ  = 96,
  parameter int IRQ_W = 7,
  parameter int CPU_W = 2
) (
  input  logic             valid_i,
  input  logic [3:0]       op_i,
  input  logic [IRQ_W-1:0] irq_i,
  input  logic [CPU_W-1:0] cpu_i,
  output logic [NIRQ-1:0]  hit_o,
  output op_e              op_o,
  output logic [NCPU-1:0]  cpu_oh_o,
  output logic             prio_wr_o
);
  logic in_range;

  assign in_range = valid_i && (int'(irq_i) < NIRQ) && (int'(cpu_i) < NCPU);
  assign op_o     = op_e'(op_i);

  for (genvar i = 0; i < NIRQ; i++) begin : g_hit
    assign hit_o[i] = in_range && (int'(irq_i) == i);
  end

  for (genvar c = 0; c < NCPU; c++) begin : g_cpu
    assign cpu_oh_o[c] = (int'(cpu_i) == c);
  end

  assign prio_wr_o = in_range && (op_o == OP_PRIO_WR);
endmodule

// File: rtl/irqst_irq_slot.sv
module irqst_irq_slot
  import irqst_pkg::*;
#(
  parameter int NCPU    = 4,
  parameter bit PRIVATE = 1'b0,
  parameter bit LEGACY  = 1'b0
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            hit_i,
  input  op_e             op_i,
  input  logic [NCPU-1:0] cpu_oh_i,
  input  logic [NCPU-1:0] line_i,
  output logic [NCPU-1:0] en_o,
  output logic [NCPU-1:0] pend_raw_o,
  output logic [NCPU-1:0] pend_o,
  output logic [NCPU-1:0] act_o,
  output logic [NCPU-1:0] grp_o
);
  localparam logic [NCPU-1:0] ALL_CPUS = '1;

  logic [NCPU-1:0] en_q, pend_q, act_q, grp_q, lvl_q;
  logic            edge_q, model_all_q;
  logic [NCPU-1:0] rise;
  logic [NCPU-1:0] en_set, en_clr, pend_set, pend_clr, act_set, act_clr, grp_set, grp_clr;
  logic [NCPU-1:0] act_clr_scope;

  assign rise = line_i & ~lvl_q;

  // active-clear scope depends on whether the interrupt is banked per CPU
  if (PRIVATE) begin : g_priv
    assign act_clr_scope = cpu_oh_i;
  end else begin : g_shared
    assign act_clr_scope = ALL_CPUS;
  end

  always_comb begin
    en_set   = '0;
    en_clr   = '0;
    pend_set = edge_q ? rise : '0;
    pend_clr = '0;
    act_set  = '0;
    act_clr  = '0;
    grp_set  = '0;
    grp_clr  = '0;
    if (hit_i) begin
      unique case (op_i)
        OP_EN_SET:   en_set   = cpu_oh_i;
        OP_EN_CLR:   en_clr   = cpu_oh_i;
        OP_PEND_SET: pend_set = pend_set | cpu_oh_i;
        OP_PEND_CLR: pend_clr = model_all_q ? ALL_CPUS : cpu_oh_i;
        OP_ACT_SET:  act_set  = cpu_oh_i;
        OP_ACT_CLR:  act_clr  = act_clr_scope;
        OP_GRP_SET:  grp_set  = cpu_oh_i;
        OP_GRP_CLR:  grp_clr  = cpu_oh_i;
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      en_q        <= '0;
      pend_q      <= '0;
      act_q       <= '0;
      grp_q       <= '0;
      lvl_q       <= '0;
      edge_q      <= 1'b0;
      model_all_q <= 1'b0;
    end else begin
      lvl_q  <= line_i;
      // set after clear: a simultaneous set wins
      en_q   <= (en_q & ~en_clr) | en_set;
      pend_q <= (pend_q & ~pend_clr) | pend_set;
      act_q  <= (act_q & ~act_clr) | act_set;
      grp_q  <= (grp_q & ~grp_clr) | grp_set;
      if (hit_i) begin
        if (op_i == OP_TRIG_EDGE)  edge_q      <= 1'b1;
        if (op_i == OP_TRIG_LEVEL) edge_q      <= 1'b0;
        if (op_i == OP_MODEL_ALL)  model_all_q <= 1'b1;
        if (op_i == OP_MODEL_ONE)  model_all_q <= 1'b0;
      end
    end
  end

  if (LEGACY) begin : g_legacy
    assign pend_o = pend_q;
  end else begin : g_normal
    assign pend_o = pend_q | (edge_q ? '0 : lvl_q);
  end

  assign en_o       = en_q;
  assign pend_raw_o = pend_q;
  assign act_o      = act_q;
  assign grp_o      = grp_q;
endmodule

// File: rtl/irqst_prio_store.sv
module irqst_prio_store #(
  parameter int NCPU   = 4,
  parameter int NIRQ   = 96,
  parameter int NPRIV  = 32,
  parameter int PRIO_W = 8,
  parameter int IRQ_W  = 7,
  parameter int CPU_W  = 2
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_i,
  input  logic [IRQ_W-1:0]  wr_irq_i,
  input  logic [CPU_W-1:0]  wr_cpu_i,
  input  logic [PRIO_W-1:0] wr_data_i,
  input  logic [IRQ_W-1:0]  rd_irq_i,
  input  logic [CPU_W-1:0]  rd_cpu_i,
  output logic [PRIO_W-1:0] rd_prio_o
);
  localparam int NBANK  = NPRIV * NCPU;
  localparam int NSHR   = NIRQ - NPRIV;
  localparam int BIDX_W = $clog2(NBANK);
  localparam int SIDX_W = $clog2(NSHR);

  logic [PRIO_W-1:0] bank_q [NBANK];
  logic [PRIO_W-1:0] shr_q  [NSHR];

  function automatic logic [BIDX_W-1:0] bidx(logic [IRQ_W-1:0] irq, logic [CPU_W-1:0] cpu);
    return BIDX_W'(BIDX_W'(irq) * BIDX_W'(NCPU) + BIDX_W'(cpu));
  endfunction

  function automatic logic [SIDX_W-1:0] sidx(logic [IRQ_W-1:0] irq);
    return SIDX_W'(irq - IRQ_W'(NPRIV));
  endfunction

  logic wr_priv, rd_priv, rd_ok;

  assign wr_priv = int'(wr_irq_i) < NPRIV;
  assign rd_priv = int'(rd_irq_i) < NPRIV;
  assign rd_ok   = (int'(rd_irq_i) < NIRQ) && (int'(rd_cpu_i) < NCPU);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int i = 0; i < NBANK; i++) bank_q[i] <= '0;
      for (int i = 0; i < NSHR; i++)  shr_q[i]  <= '0;
    end else if (wr_i) begin
      if (wr_priv) bank_q[bidx(wr_irq_i, wr_cpu_i)] <= wr_data_i;
      else         shr_q[sidx(wr_irq_i)]            <= wr_data_i;
    end
  end

  always_comb begin
    rd_prio_o = '0;
    if (rd_ok) begin
      if (rd_priv) rd_prio_o = bank_q[bidx(rd_irq_i, rd_cpu_i)];
      else         rd_prio_o = shr_q[sidx(rd_irq_i)];
    end
  end
endmodule

// File: rtl/irqst_query.sv
module irqst_query #(
  parameter int NCPU  = 4,
  parameter int NIRQ  = 96,
  parameter int IRQ_W = 7,
  parameter int CPU_W = 2
) (
  input  logic [NIRQ-1:0][NCPU-1:0] en_all_i,
  input  logic [NIRQ-1:0][NCPU-1:0] pend_all_i,
  input  logic [NIRQ-1:0][NCPU-1:0] act_all_i,
  input  logic [NIRQ-1:0][NCPU-1:0] grp_all_i,
  input  logic [IRQ_W-1:0]          irq_i,
  input  logic [CPU_W-1:0]          cpu_i,
  output logic                      en_o,
  output logic                      pend_o,
  output logic                      act_o,
  output logic                      grp_o
);
  always_comb begin
    en_o   = 1'b0;
    pend_o = 1'b0;
    act_o  = 1'b0;
    grp_o  = 1'b0;
    for (int i = 0; i < NIRQ; i++) begin
      for (int c = 0; c < NCPU; c++) begin
        if (int'(irq_i) == i && int'(cpu_i) == c) begin
          en_o   = en_all_i[i][c];
          pend_o = pend_all_i[i][c];
          act_o  = act_all_i[i][c];
          grp_o  = grp_all_i[i][c];
        end
      end
    end
  end
endmodule

// File: rtl/irq_state_tracker.sv
module irq_state_tracker
  import irqst_pkg::*;
#(
  parameter int  NCPU   = 4,
  parameter int  NIRQ   = 96,
  parameter int  NPRIV  = 32,
  parameter int  PRIO_W = 8,
  parameter bit  LEGACY = 1'b0,
  localparam int IRQ_W  = $clog2(NIRQ + 1),
  localparam int CPU_W  = (NCPU > 1) ? $clog2(NCPU) : 1
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic                 cmd_valid_i,
  input  logic [3:0]           cmd_op_i,
  input  logic [IRQ_W-1:0]     cmd_irq_i,
  input  logic [CPU_W-1:0]     cmd_cpu_i,
  input  logic [PRIO_W-1:0]    cmd_data_i,
  input  logic [NIRQ*NCPU-1:0] line_i,
  input  logic [IRQ_W-1:0]     q_irq_i,
  input  logic [CPU_W-1:0]     q_cpu_i,
  output logic                 q_enabled_o,
  output logic                 q_pending_o,
  output logic                 q_active_o,
  output logic                 q_group_o,
  output logic [PRIO_W-1:0]    q_prio_o
);
  logic [NIRQ-1:0]            hit;
  op_e                        op;
  logic [NCPU-1:0]            cpu_oh;
  logic                       prio_wr;
  logic [NIRQ-1:0][NCPU-1:0]  en_all, pend_raw_all, pend_all, act_all, grp_all;

  irqst_cmd_decode #(
    .NCPU(NCPU), .NIRQ(NIRQ), .IRQ_W(IRQ_W), .CPU_W(CPU_W)
  ) u_dec (
    .valid_i  (cmd_valid_i),
    .op_i     (cmd_op_i),
    .irq_i    (cmd_irq_i),
    .cpu_i    (cmd_cpu_i),
    .hit_o    (hit),
    .op_o     (op),
    .cpu_oh_o (cpu_oh),
    .prio_wr_o(prio_wr)
  );

  for (genvar i = 0; i < NIRQ; i++) begin : g_slot
    irqst_irq_slot #(
      .NCPU(NCPU), .PRIVATE(i < NPRIV), .LEGACY(LEGACY)
    ) u_slot (
      .clk_i     (clk_i),
      .rst_ni    (rst_ni),
      .hit_i     (hit[i]),
      .op_i      (op),
      .cpu_oh_i  (cpu_oh),
      .line_i    (line_i[i*NCPU +: NCPU]),
      .en_o      (en_all[i]),
      .pend_raw_o(pend_raw_all[i]),
      .pend_o    (pend_all[i]),
      .act_o     (act_all[i]),
      .grp_o     (grp_all[i])
    );
  end

  irqst_prio_store #(
    .NCPU(NCPU), .NIRQ(NIRQ), .NPRIV(NPRIV), .PRIO_W(PRIO_W),
    .IRQ_W(IRQ_W), .CPU_W(CPU_W)
  ) u_prio (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .wr_i     (prio_wr),
    .wr_irq_i (cmd_irq_i),
    .wr_cpu_i (cmd_cpu_i),
    .wr_data_i(cmd_data_i),
    .rd_irq_i (q_irq_i),
    .rd_cpu_i (q_cpu_i),
    .rd_prio_o(q_prio_o)
  );

  irqst_query #(
    .NCPU(NCPU), .NIRQ(NIRQ), .IRQ_W(IRQ_W), .CPU_W(CPU_W)
  ) u_query (
    .en_all_i  (en_all),
    .pend_all_i(pend_all),
    .act_all_i (act_all),
    .grp_all_i (grp_all),
    .irq_i     (q_irq_i),
    .cpu_i     (q_cpu_i),
    .en_o      (q_enabled_o),
    .pend_o    (q_pending_o),
    .act_o     (q_active_o),
    .grp_o     (q_group_o)
  );
endmodule

// File: rtl/irq_state_tracker_chk.sv
module irq_state_tracker_chk
  import irqst_pkg::*;
#(
  parameter int NCPU   = 4,
  parameter int NIRQ   = 96,
  parameter int NPRIV  = 32,
  parameter int PRIO_W = 8,
  parameter bit LEGACY = 1'b0,
  parameter int IRQ_W  = 7,
  parameter int CPU_W  = 2
) (
  input logic                      clk_i,
  input logic                      rst_ni,
  input logic                      cmd_valid_i,
  input logic [3:0]                cmd_op_i,
  input logic [IRQ_W-1:0]          cmd_irq_i,
  input logic [CPU_W-1:0]          cmd_cpu_i,
  input logic [IRQ_W-1:0]          q_irq_i,
  input logic [CPU_W-1:0]          q_cpu_i,
  input logic                      q_pending_o,
  input logic                      q_active_o,
  input logic [PRIO_W-1:0]         q_prio_o,
  input logic [NIRQ-1:0][NCPU-1:0] act_all,
  input logic [NIRQ-1:0][NCPU-1:0] pend_raw_all
);
  logic cmd_ok, q_ok;
  assign cmd_ok = cmd_valid_i && (int'(cmd_irq_i) < NIRQ) && (int'(cmd_cpu_i) < NCPU);
  assign q_ok   = (int'(q_irq_i) < NIRQ) && (int'(q_cpu_i) < NCPU);

  AST_ACT_SET_REQ: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cmd_ok && cmd_op_i == OP_ACT_SET) |=> act_all[$past(cmd_irq_i)][$past(cmd_cpu_i)]); // R5

  AST_ACT_CLR_SHARED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cmd_ok && cmd_op_i == OP_ACT_CLR && int'(cmd_irq_i) >= NPRIV)
      |=> act_all[$past(cmd_irq_i)] == '0); // R7

  AST_ACT_CLR_PRIV: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cmd_ok && cmd_op_i == OP_ACT_CLR && int'(cmd_irq_i) < NPRIV)
      |=> (act_all[$past(cmd_irq_i)] | (NCPU'(1) << $past(cmd_cpu_i)))
          == ($past(act_all[cmd_irq_i]) | (NCPU'(1) << $past(cmd_cpu_i)))
          && !act_all[$past(cmd_irq_i)][$past(cmd_cpu_i)]); // R7

  AST_STORED_READS_PEND: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (q_ok && pend_raw_all[q_irq_i][q_cpu_i]) |-> q_pending_o); // R2

  AST_LEGACY_STORED_ONLY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (LEGACY && q_ok) |-> q_pending_o == pend_raw_all[q_irq_i][q_cpu_i]); // R3

  AST_OOR_QUERY_ZERO: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (int'(q_irq_i) >= NIRQ) |-> (!q_pending_o && !q_active_o && q_prio_o == '0)); // R10
endmodule

bind irq_state_tracker irq_state_tracker_chk #(
  .NCPU(NCPU), .NIRQ(NIRQ), .NPRIV(NPRIV), .PRIO_W(PRIO_W),
  .LEGACY(LEGACY), .IRQ_W(IRQ_W), .CPU_W(CPU_W)
) u_chk (.*);

// File: tb/irq_state_tracker_tb.sv
module irq_state_tracker_tb;
  import irqst_pkg::*;

  localparam int NCPU = 4;
  localparam int NIRQ = 96;

  logic             clk = 1'b0;
  logic             rst_n = 1'b0;
  logic             cmd_valid = 1'b0;
  logic [3:0]       cmd_op = '0;
  logic [6:0]       cmd_irq = '0;
  logic [1:0]       cmd_cpu = '0;
  logic [7:0]       cmd_data = '0;
  logic [NIRQ*NCPU-1:0] line = '0;
  logic [6:0]       q_irq = '0;
  logic [1:0]       q_cpu = '0;
  logic             q_en, q_pend, q_act, q_grp;
  logic [7:0]       q_prio;
  logic             l_en, l_pend, l_act, l_grp;
  logic [7:0]       l_prio;

  int  n_vec = 0;
  int  n_err = 0;
  bit  done  = 1'b0;

  always #10 clk = ~clk;

  irq_state_tracker #(.LEGACY(1'b0)) u_dut (
    .clk_i(clk), .rst_ni(rst_n), .cmd_valid_i(cmd_valid), .cmd_op_i(cmd_op),
    .cmd_irq_i(cmd_irq), .cmd_cpu_i(cmd_cpu), .cmd_data_i(cmd_data), .line_i(line),
    .q_irq_i(q_irq), .q_cpu_i(q_cpu), .q_enabled_o(q_en), .q_pending_o(q_pend),
    .q_active_o(q_act), .q_group_o(q_grp), .q_prio_o(q_prio));

  irq_state_tracker #(.LEGACY(1'b1)) u_leg (
    .clk_i(clk), .rst_ni(rst_n), .cmd_valid_i(cmd_valid), .cmd_op_i(cmd_op),
    .cmd_irq_i(cmd_irq), .cmd_cpu_i(cmd_cpu), .cmd_data_i(cmd_data), .line_i(line),
    .q_irq_i(q_irq), .q_cpu_i(q_cpu), .q_enabled_o(l_en), .q_pending_o(l_pend),
    .q_active_o(l_act), .q_group_o(l_grp), .q_prio_o(l_prio));

  task automatic chk(string req, string what, logic [31:0] got, logic [31:0] exp);
    n_vec++;
    if (got !== exp) begin
      n_err++;
      $display("FAIL %s %s: got %0h expected %0h", req, what, got, exp);
    end
  endtask

  task automatic issue(op_e op, int irq, int cpu, int data = 0);
    @(negedge clk);
    cmd_valid = 1'b1;
    cmd_op    = op;
    cmd_irq   = 7'(irq);
    cmd_cpu   = 2'(cpu);
    cmd_data  = 8'(data);
    @(negedge clk);
    cmd_valid = 1'b0;
  endtask

  task automatic look(int irq, int cpu);
    q_irq = 7'(irq);
    q_cpu = 2'(cpu);
    #1;
  endtask

  task automatic drive_line(int irq, int cpu, logic v);
    @(negedge clk);
    line[irq*NCPU+cpu] = v;
    @(negedge clk);
  endtask

  task automatic t_reset();
    look(5, 0);
    chk("R1", "enabled", 32'(q_en), 0);
    chk("R1", "pending", 32'(q_pend), 0);
    chk("R1", "active", 32'(q_act), 0);
    chk("R1", "group", 32'(q_grp), 0);
    chk("R1", "prio", 32'(q_prio), 0);
    look(70, 3);
    chk("R1", "shared prio", 32'(q_prio), 0);
  endtask

  task automatic t_level();
    drive_line(40, 1, 1'b1);
    look(40, 1);
    chk("R2", "level high pending (reset level-trig R1)", 32'(q_pend), 1);
    chk("R3", "legacy ignores line", 32'(l_pend), 0);
    look(40, 0);
    chk("R2", "other cpu line low", 32'(q_pend), 0);
    drive_line(40, 1, 1'b0);
    look(40, 1);
    chk("R2", "line dropped", 32'(q_pend), 0);
  endtask

  task automatic t_edge();
    issue(OP_TRIG_EDGE, 41, 0);
    drive_line(41, 2, 1'b1);
    look(41, 2);
    chk("R4", "edge sets pending", 32'(q_pend), 1);
    chk("R4", "legacy edge sets stored", 32'(l_pend), 1);
    look(41, 0);
    chk("R4", "other cpu untouched", 32'(q_pend), 0);
    drive_line(41, 2, 1'b0);
    look(41, 2);
    chk("R4", "held after fall", 32'(q_pend), 1);
    issue(OP_PEND_CLR, 41, 2);
    look(41, 2);
    chk("R6", "edge cleared", 32'(q_pend), 0);
  endtask

  task automatic t_pend_clr();
    issue(OP_PEND_SET, 50, 0);
    issue(OP_PEND_SET, 50, 1);
    look(50, 2);
    chk("R5", "pend set only requester", 32'(q_pend), 0);
    issue(OP_PEND_CLR, 50, 0);
    look(50, 0);
    chk("R6", "one-model clears requester", 32'(q_pend), 0);
    look(50, 1);
    chk("R6", "one-model keeps other", 32'(q_pend), 1);
    issue(OP_MODEL_ALL, 50, 0);
    issue(OP_PEND_CLR, 50, 3);
    look(50, 1);
    chk("R6", "all-model clears all", 32'(q_pend), 0);
    drive_line(51, 2, 1'b1);
    issue(OP_PEND_SET, 51, 2);
    issue(OP_PEND_CLR, 51, 2);
    look(51, 2);
    chk("R6", "level high stays pending", 32'(q_pend), 1);
    chk("R3", "legacy cleared despite line", 32'(l_pend), 0);
    drive_line(51, 2, 1'b0);
  endtask

  task automatic t_active();
    issue(OP_ACT_SET, 10, 0);
    issue(OP_ACT_SET, 10, 1);
    look(10, 2);
    chk("R5", "act set only requester", 32'(q_act), 0);
    issue(OP_ACT_CLR, 10, 0);
    look(10, 0);
    chk("R7", "private clears requester", 32'(q_act), 0);
    look(10, 1);
    chk("R7", "private keeps other", 32'(q_act), 1);
    issue(OP_ACT_SET, 60, 0);
    issue(OP_ACT_SET, 60, 3);
    issue(OP_ACT_CLR, 60, 1);
    look(60, 0);
    chk("R7", "shared clears cpu0", 32'(q_act), 0);
    look(60, 3);
    chk("R7", "shared clears cpu3", 32'(q_act), 0);
  endtask

  task automatic t_en_grp();
    issue(OP_EN_SET, 70, 2);
    issue(OP_GRP_SET, 70, 1);
    look(70, 2);
    chk("R5", "enable requester", 32'(q_en), 1);
    chk("R5", "group not on cpu2", 32'(q_grp), 0);
    look(70, 0);
    chk("R5", "enable not other", 32'(q_en), 0);
    look(70, 1);
    chk("R5", "group requester", 32'(q_grp), 1);
    issue(OP_EN_SET, 70, 0);
    issue(OP_EN_CLR, 70, 2);
    look(70, 0);
    chk("R5", "enable clr keeps other", 32'(q_en), 1);
    look(70, 2);
    chk("R5", "enable cleared", 32'(q_en), 0);
  endtask

  task automatic t_prio();
    issue(OP_PRIO_WR, 7, 0, 'hA5);
    issue(OP_PRIO_WR, 7, 1, 'h3C);
    look(7, 0);
    chk("R8", "bank cpu0", 32'(q_prio), 'hA5);
    look(7, 1);
    chk("R8", "bank cpu1", 32'(q_prio), 'h3C);
    look(7, 2);
    chk("R8", "bank cpu2 untouched", 32'(q_prio), 0);
    issue(OP_PRIO_WR, 80, 3, 'h77);
    look(80, 0);
    chk("R8", "shared seen by cpu0", 32'(q_prio), 'h77);
    look(80, 3);
    chk("R8", "shared seen by cpu3", 32'(q_prio), 'h77);
  endtask

  task automatic t_set_wins();
    issue(OP_TRIG_EDGE, 90, 0);
    @(negedge clk);
    line[90*NCPU+1] = 1'b1;
    cmd_valid = 1'b1;
    cmd_op    = OP_PEND_CLR;
    cmd_irq   = 7'd90;
    cmd_cpu   = 2'd1;
    @(negedge clk);
    cmd_valid = 1'b0;
    look(90, 1);
    chk("R9", "rise beats clear", 32'(q_pend), 1);
    drive_line(90, 1, 1'b0);
  endtask

  task automatic t_oor();
    issue(OP_ACT_SET, 100, 0);
    issue(OP_PRIO_WR, 100, 0, 'hEE);
    look(4, 0);
    chk("R10", "alias irq4 active", 32'(q_act), 0);
    chk("R10", "alias irq4 prio", 32'(q_prio), 0);
    look(36, 0);
    chk("R10", "alias irq36 active", 32'(q_act), 0);
    chk("R10", "alias irq36 prio", 32'(q_prio), 0);
    look(100, 0);
    chk("R10", "oor query active", 32'(q_act), 0);
    chk("R10", "oor query prio", 32'(q_prio), 0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_level();
    t_edge();
    t_pend_clr();
    t_active();
    t_en_grp();
    t_prio();
    t_set_wins();
    t_oor();
    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_err);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_vec++;
      n_err++;
      $display("FAIL watchdog: got hung expected done");
      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_err);
      $finish;
    end
  end
endmodule